// File: doc/BRIEF.md
# Configurable Logic-Array Output Macrocell

This block is a single output cell of a small programmable logic array. It takes a vector of product-term bits and ORs together the ones its enable mask keeps. The result either goes straight to the pin or passes through a one-bit storage element. That element can act as a D, T or JK flip-flop. A polarity bit can invert the chosen value. The same value drives the pin, returns to the array as a feedback term and can be read back by the processor.

The storage element updates on a single system clock. Its update enable comes either from a dedicated product-term clock or from a global clock enable, chosen by a configuration bit. Product-term clear and preset override any update, with clear taking precedence. A processor load strobe writes a data bit straight into the register without going through the array. A product-term output enable decides whether the pin is driven.

Top module: `mc_output_cell`

## Requirements
- R1: While reset is high and on the first cycle after it, the register holds 0, so in registered mode with polarity 0 the pin value, feedback and readback are all 0.
- R2: The sum is the OR of the product terms whose mask bit is 1. A term whose mask bit is 0 has no effect on the sum.
- R3: In D mode (ff_mode_i = 0), on an edge where the selected enable is 1, the register takes the sum. On an edge where that enable is 0, the register keeps its value.
- R4: In T mode (ff_mode_i = 1), on an enabled edge the register inverts when the sum is 1 and holds when the sum is 0.
- R5: In JK mode (ff_mode_i = 2), J is the OR of the masked terms at indices 0 to NUM_PT/2-1 and K is the OR of the masked terms at the remaining indices. On an enabled edge, J alone sets the register, K alone clears it, both together invert it, and neither holds it. The mode value 3 holds the register.
- R6: With clk_src_i = 0 the update enable is glb_ce_i and pt_clk_i is ignored. With clk_src_i = 1 the update enable is pt_clk_i and glb_ce_i is ignored.
- R7: pt_clear_i set to 1 drives the register to 0 at the next edge. This wins over preset, load and any enabled update.
- R8: pt_preset_i set to 1 without clear drives the register to 1 at the next edge. This wins over load and any enabled update.
- R9: ld_i set to 1 without clear or preset writes ld_data_i into the register at the next edge. This happens whatever the enable, and the update from the array is ignored.
- R10: With comb_sel_i = 1 the cell value is the current sum. With comb_sel_i = 0 it is the register.
- R11: With pol_i = 1 the cell value is inverted on pin_o, fb_o and rd_o alike. A load still writes the data bit into the register itself, not inverted.
- R12: pin_oe_o follows pt_oe_i at once. fb_o and rd_o always equal pin_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| pt_i | input | NUM_PT | Product-term bits from the array |
| pt_mask_i | input | NUM_PT | Per-term enable mask |
| ff_mode_i | input | 2 | Storage type: 0 D, 1 T, 2 JK, 3 hold |
| comb_sel_i | input | 1 | 1 selects the combinational sum, 0 the register |
| pol_i | input | 1 | 1 inverts the cell value |
| clk_src_i | input | 1 | 0 selects the global enable, 1 the product-term clock |
| pt_clk_i | input | 1 | Product-term clock enable |
| glb_ce_i | input | 1 | Global clock enable |
| pt_preset_i | input | 1 | Product-term preset |
| pt_clear_i | input | 1 | Product-term clear |
| pt_oe_i | input | 1 | Product-term output enable |
| ld_i | input | 1 | Processor load strobe |
| ld_data_i | input | 1 | Processor load data bit |
| pin_o | output | 1 | Pin value |
| pin_oe_o | output | 1 | Pin drive enable |
| fb_o | output | 1 | Feedback term to the array |
| rd_o | output | 1 | Processor readback bit |

## Verification
The sum is tried with a single unmasked term, with the same term masked off and with no terms. Together these show that the mask really gates terms rather than only the OR. The register is run in each mode with inputs that hit every distinct case: D with set and clear data, T with the sum at 1 and at 0, and JK with J only, K only, both and neither. These patterns separate the modes from one another. The overrides are stacked so that clear, preset and load are each active with everything below them also asserted, which exposes any swapped priority. Polarity, clock-source and enable patterns each check that the unused input has no effect.

// File: rtl/mc_pkg.sv
package mc_pkg;

  typedef enum logic [1:0] {
    MODE_D    = 2'd0,
    MODE_T    = 2'd1,
    MODE_JK   = 2'd2,
    MODE_HOLD = 2'd3
  } ff_mode_t;

endpackage

// File: rtl/mc_term_sum.sv
module mc_term_sum #(
  parameter int NUM_PT = 10
) (
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [NUM_PT-1:0] mask_i,
  output logic              sum_o,
  output logic              j_o,
  output logic              k_o
);
  localparam int HALF = NUM_PT / 2;

  logic [NUM_PT-1:0] kept;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_gate
    assign kept[g] = pt_i[g] & mask_i[g];
  end

  assign sum_o = |kept;
  assign j_o   = |kept[HALF-1:0];
  assign k_o   = |kept[NUM_PT-1:HALF];

  initial begin
    assert (NUM_PT >= 2) else $error("NUM_PT must be at least 2");
  end

endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic [1:0] mode_i,
  input  logic       clk_src_i,
  input  logic       pt_clk_i,
  input  logic       glb_ce_i,
  input  logic       preset_i,
  input  logic       clear_i,
  input  logic       ld_i,
  input  logic       ld_data_i,
  input  logic       sum_i,
  input  logic       j_i,
  input  logic       k_i,
  output logic       q_o
);
  ff_mode_t mode;
  logic     ce;
  logic     q_upd;
  logic     q_nxt;
  logic     q;

  assign mode = ff_mode_t'(mode_i);
  assign ce   = clk_src_i ? pt_clk_i : glb_ce_i;

  always_comb begin
    unique case (mode)
      MODE_D:  q_upd = sum_i;
      MODE_T:  q_upd = q ^ sum_i;
      MODE_JK: q_upd = (j_i & ~q) | (~k_i & q);
      default: q_upd = q;
    endcase
  end

  always_comb begin
    if (clear_i)       q_nxt = 1'b0;
    else if (preset_i) q_nxt = 1'b1;
    else if (ld_i)     q_nxt = ld_data_i;
    else if (ce)       q_nxt = q_upd;
    else               q_nxt = q;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) q <= 1'b0;
    else       q <= q_nxt;
  end

  assign q_o = q;

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    clear_i |=> !q) else $error("clear"); // R7
  AST_PRESET_SETS: assert property (@(posedge clk_i) disable iff (rst_i)
    (preset_i && !clear_i) |=> q) else $error("preset"); // R8
  AST_LOAD_WRITES: assert property (@(posedge clk_i) disable iff (rst_i)
    (ld_i && !preset_i && !clear_i) |=> (q == $past(ld_data_i))) else $error("load"); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ld_i && !preset_i && !clear_i && !(clk_src_i ? pt_clk_i : glb_ce_i)) |=> $stable(q))
    else $error("hold"); // R3
  AST_D_FOLLOWS: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == 2'd0 && (clk_src_i ? pt_clk_i : glb_ce_i) && !ld_i && !preset_i && !clear_i)
    |=> (q == $past(sum_i))) else $error("d mode"); // R3

endmodule

// File: rtl/mc_out_stage.sv
module mc_out_stage (
  input  logic comb_sel_i,
  input  logic pol_i,
  input  logic sum_i,
  input  logic q_i,
  input  logic oe_i,
  output logic pin_o,
  output logic pin_oe_o,
  output logic fb_o,
  output logic rd_o
);
  logic cell_raw;
  logic cell_val;

  assign cell_raw = comb_sel_i ? sum_i : q_i;
  assign cell_val = cell_raw ^ pol_i;

  assign pin_o    = cell_val;
  assign fb_o     = cell_val;
  assign rd_o     = cell_val;
  assign pin_oe_o = oe_i;

  always_comb begin
    AST_POL_INVERTS: assert (!(comb_sel_i && pol_i) || (pin_o != sum_i)) else $error("pol"); // R11
  end

endmodule

// File: rtl/mc_output_cell.sv
module mc_output_cell #(
  parameter int NUM_PT = 10
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [NUM_PT-1:0] pt_mask_i,
  input  logic [1:0]        ff_mode_i,
  input  logic              comb_sel_i,
  input  logic              pol_i,
  input  logic              clk_src_i,
  input  logic              pt_clk_i,
  input  logic              glb_ce_i,
  input  logic              pt_preset_i,
  input  logic              pt_clear_i,
  input  logic              pt_oe_i,
  input  logic              ld_i,
  input  logic              ld_data_i,
  output logic              pin_o,
  output logic              pin_oe_o,
  output logic              fb_o,
  output logic              rd_o
);
  logic sum, j, k, q;

  mc_term_sum #(.NUM_PT(NUM_PT)) u_sum (
    .pt_i   (pt_i),
    .mask_i (pt_mask_i),
    .sum_o  (sum),
    .j_o    (j),
    .k_o    (k)
  );

  mc_store u_store (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .mode_i    (ff_mode_i),
    .clk_src_i (clk_src_i),
    .pt_clk_i  (pt_clk_i),
    .glb_ce_i  (glb_ce_i),
    .preset_i  (pt_preset_i),
    .clear_i   (pt_clear_i),
    .ld_i      (ld_i),
    .ld_data_i (ld_data_i),
    .sum_i     (sum),
    .j_i       (j),
    .k_i       (k),
    .q_o       (q)
  );

  mc_out_stage u_out (
    .comb_sel_i (comb_sel_i),
    .pol_i      (pol_i),
    .sum_i      (sum),
    .q_i        (q),
    .oe_i       (pt_oe_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o),
    .fb_o       (fb_o),
    .rd_o       (rd_o)
  );

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    rst_i |=> (!comb_sel_i && !pol_i) |-> !pin_o) else $error("reset"); // R1

endmodule

// File: tb/mc_output_cell_tb_top.sv
module mc_output_cell_tb_top;
  localparam int NPT = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NPT-1:0] pt = '0;
  logic [NPT-1:0] mask = '1;
  logic [1:0] mode = 2'd0;
  logic comb = 1'b0, pol = 1'b0, src = 1'b0, ptclk = 1'b0, gce = 1'b0;
  logic pre = 1'b0, clr = 1'b0, oe = 1'b1, ld = 1'b0, ldd = 1'b0;
  logic pin, pin_oe, fb, rd;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  mc_output_cell #(.NUM_PT(NPT)) dut_i (
    .clk_i(clk), .rst_i(rst), .pt_i(pt), .pt_mask_i(mask), .ff_mode_i(mode),
    .comb_sel_i(comb), .pol_i(pol), .clk_src_i(src), .pt_clk_i(ptclk),
    .glb_ce_i(gce), .pt_preset_i(pre), .pt_clear_i(clr), .pt_oe_i(oe),
    .ld_i(ld), .ld_data_i(ldd), .pin_o(pin), .pin_oe_o(pin_oe), .fb_o(fb), .rd_o(rd)
  );

  // expected vector order: {pin, oe, fb, rd}; checked 5 ns after the next rising edge
  task automatic cyc(input logic [3:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    #5;
    if (exp_q.size() != 0) begin
      logic [3:0] e;
      string t;
      logic [3:0] a;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {pin, pin_oe, fb, rd};
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s: actual=%b expected=%b", t, a, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    cyc(4'b0100, "R1 reset held");
    rst = 1'b0;
    cyc(4'b0100, "R1 first cycle after reset");

    comb = 1'b1; pt = 10'b00_0000_0100;
    cyc(4'b1111, "R2 one unmasked term");
    mask[2] = 1'b0;
    cyc(4'b0100, "R2 masked term ignored");
    mask = '1; pt = '0;
    cyc(4'b0100, "R2 no terms");

    comb = 1'b0; gce = 1'b1; pt = 10'b1;
    cyc(4'b1111, "R3 D load 1");
    gce = 1'b0; pt = '0;
    cyc(4'b1111, "R3 disabled edge holds");
    gce = 1'b1;
    cyc(4'b0100, "R3 D load 0");

    gce = 1'b0; comb = 1'b1; pt = 10'b1;
    cyc(4'b1111, "R10 combinational path");
    comb = 1'b0;
    cyc(4'b0100, "R10 registered path");

    src = 1'b1; gce = 1'b1; ptclk = 1'b0;
    cyc(4'b0100, "R6 global enable ignored");
    ptclk = 1'b1;
    cyc(4'b1111, "R6 term clock used");
    src = 1'b0; ptclk = 1'b1; gce = 1'b0; pt = '0;
    cyc(4'b1111, "R6 term clock ignored");
    gce = 1'b1; ptclk = 1'b0;
    cyc(4'b0100, "R6 global enable used");

    mode = 2'd1; pt = 10'b1;
    cyc(4'b1111, "R4 toggle up");
    cyc(4'b0100, "R4 toggle down");
    pt = '0;
    cyc(4'b0100, "R4 sum 0 holds");

    mode = 2'd2; pt = 10'b00_0000_0010;
    cyc(4'b1111, "R5 J sets");
    pt = 10'b00_1000_0000;
    cyc(4'b0100, "R5 K clears");
    pt = 10'b00_1000_0010;
    cyc(4'b1111, "R5 J and K toggle");
    cyc(4'b0100, "R5 J and K toggle back");
    pt = 10'b00_0000_0010; mask[1] = 1'b0;
    cyc(4'b0100, "R5 masked J holds");
    mask = '1; pt = '0; mode = 2'd3; ld = 1'b1; ldd = 1'b1;
    cyc(4'b1111, "R9 load in hold mode");
    ld = 1'b0; pt = 10'b00_1000_0000;
    cyc(4'b1111, "R5 mode 3 holds");

    mode = 2'd0; gce = 1'b0; pt = '0; ld = 1'b1; ldd = 1'b0;
    cyc(4'b0100, "R9 load 0 with enable off");
    ld = 1'b1; ldd = 1'b0; gce = 1'b1; pt = 10'b1;
    cyc(4'b0100, "R9 load beats update");

    pre = 1'b1; ld = 1'b1; ldd = 1'b0; gce = 1'b1; pt = '0;
    cyc(4'b1111, "R8 preset beats load and update");
    clr = 1'b1; pre = 1'b1; ld = 1'b1; ldd = 1'b1; pt = 10'b1;
    cyc(4'b0100, "R7 clear beats all");
    clr = 1'b0; pre = 1'b0; ld = 1'b0; gce = 1'b0; pt = '0;

    pol = 1'b1; ld = 1'b1; ldd = 1'b1;
    cyc(4'b0100, "R11 loaded 1 reads inverted");
    ld = 1'b0; comb = 1'b1;
    cyc(4'b1111, "R11 comb sum 0 inverted");
    comb = 1'b0; oe = 1'b0;
    cyc(4'b0000, "R12 drive off");
    pol = 1'b0;
    cyc(4'b1011, "R12 pin value with drive off");
    oe = 1'b1;
    cyc(4'b1111, "R12 drive on");

    repeat (3) @(negedge clk);
    done = 1'b1;
    summary();
  end

endmodule